// File: doc/BRIEF.md
# Four-Instruction Single-Cycle Integer Core

This block is a small 32-bit processor core that completes one instruction per clock. It fetches a word from an external instruction memory, decodes it, reads two operands from a 32 x 32-bit register file, and either writes back an arithmetic result or performs one word transfer on an external data memory port. The core recognises exactly four encodings: register add, register subtract, word load and word store. Every other encoding passes through as a no-operation.

Both memories are outside the core and are read combinationally within the cycle. The instruction port carries a word address. The data port carries a byte address, formed by adding a sign-extended 16-bit offset to a base register. Word accesses must sit on 4-byte boundaries. An access off such a boundary is flagged and has no effect. Register writes land at the clock edge, so the next instruction sees the result.

Top module: `qcore_top`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, so `imem_addr` (the program counter divided by 4) reads 0, and `dmem_we` stays low during reset.
- R2: Out of reset, `imem_addr` increases by exactly 1 (4 bytes) at every rising edge.
- R3: An instruction with bits [31:26]=0, bits [10:6]=0 and bits [5:0]=32 writes the 32-bit sum, modulo 2^32, of the registers selected by bits [25:21] and bits [20:16] into the register selected by bits [15:11].
- R4: The same layout with bits [5:0]=34 writes the first source minus the second source, modulo 2^32, into the destination register.
- R5: Register 0 always reads as zero, and any write aimed at it is discarded.
- R6: An instruction with bits [31:26]=35 reads the data word at the byte address (register[bits 25:21] + offset) into the register selected by bits [20:16]. The instruction that follows sees the loaded value.
- R7: An instruction with bits [31:26]=43 drives `dmem_we` high for that cycle, puts the byte address on `dmem_addr` and the register selected by bits [20:16] on `dmem_wdata`.
- R8: The offset is bits [15:0] sign-extended to 32 bits, so negative offsets address below the base.
- R9: A load or store whose byte address has nonzero bits [1:0] raises `align_fault` for that cycle. It then writes no memory and no register.
- R10: Any other encoding, including an add or subtract with nonzero bits [10:6], changes no register and no memory, and leaves `dmem_we` and `align_fault` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 30 | Word address of the instruction being executed |
| imem_data | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dmem_addr | output | 32 | Byte address of the current load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by memory at the rising edge |
| dmem_rdata | input | 32 | Load data returned for `dmem_addr` in the same cycle |
| align_fault | output | 1 | Current load or store is not on a 4-byte boundary |

## Verification
The memory-port outputs (`dmem_we`, `dmem_addr`, `dmem_wdata`, `align_fault`) depend only on the instruction at the current `imem_addr`. The bench therefore samples them on the falling edge of the same cycle in which that address is presented. Register results show up one edge later, when a following instruction reads them. The bench brings them out with a store and checks its memory model after the store's rising edge. The program counter moves one word per rising edge, so each check first waits until `imem_addr` equals the index of the instruction under test. Rejected writes are checked the same way: a later store or a memory read-back shows the unchanged value.

// File: rtl/qcore_pkg.sv
package qcore_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 16;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;
  localparam logic [5:0] FN_ADD    = 6'd32;
  localparam logic [5:0] FN_SUB    = 6'd34;

  typedef enum logic [1:0] {
    K_NOP   = 2'd0,
    K_ARITH = 2'd1,
    K_LOAD  = 2'd2,
    K_STORE = 2'd3
  } kind_t;

  typedef struct packed {
    kind_t             kind;
    logic              do_sub;
    logic [RIDX_W-1:0] src_a;
    logic [RIDX_W-1:0] src_b;
    logic [RIDX_W-1:0] dst;
    logic [XLEN-1:0]   offset;
  } ctrl_t;
endpackage

// File: rtl/qcore_decode.sv
module qcore_decode
  import qcore_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] sh;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];
  assign sh  = instr[10:6];

  always_comb begin
    ctrl.src_a  = instr[25:21];
    ctrl.src_b  = instr[20:16];
    ctrl.dst    = instr[20:16];
    ctrl.do_sub = 1'b0;
    ctrl.kind   = K_NOP;
    ctrl.offset = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    if (opc == OPC_REG && sh == 5'd0 && (fn == FN_ADD || fn == FN_SUB)) begin
      ctrl.kind   = K_ARITH;
      ctrl.dst    = instr[15:11];
      ctrl.do_sub = (fn == FN_SUB);
    end else if (opc == OPC_LOAD) begin
      ctrl.kind = K_LOAD;
    end else if (opc == OPC_STORE) begin
      ctrl.kind = K_STORE;
    end
  end
endmodule

// File: rtl/qcore_regfile.sv
module qcore_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) cells[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : cells[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : cells[raddr_b];
endmodule

// File: rtl/qcore_alu.sv
module qcore_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] y
);
  assign y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/qcore_top.sv
module qcore_top
  import qcore_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-3:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            align_fault
);
  logic [XLEN-3:0] pc_word;
  ctrl_t           ctrl;
  logic [XLEN-1:0] val_a, val_b, alu_y, agen, wb_data;
  logic            mem_op, off_word, rf_we;

  always_ff @(posedge clk) begin
    if (rst) pc_word <= '0;
    else     pc_word <= pc_word + 1'b1;
  end
  assign imem_addr = pc_word;

  qcore_decode u_dec (.instr(imem_data), .ctrl(ctrl));

  qcore_regfile #(.DEPTH(NREG), .WIDTH(XLEN)) u_rf (
    .clk(clk), .we(rf_we), .waddr(ctrl.dst), .wdata(wb_data),
    .raddr_a(ctrl.src_a), .raddr_b(ctrl.src_b),
    .rdata_a(val_a), .rdata_b(val_b)
  );

  qcore_alu #(.WIDTH(XLEN)) u_alu (
    .a(val_a), .b(val_b), .sub(ctrl.do_sub), .y(alu_y)
  );

  assign agen     = val_a + ctrl.offset;
  assign mem_op   = (ctrl.kind == K_LOAD) || (ctrl.kind == K_STORE);
  assign off_word = |agen[1:0];

  assign align_fault = mem_op && off_word && !rst;
  assign dmem_addr   = agen;
  assign dmem_wdata  = val_b;
  assign dmem_we     = (ctrl.kind == K_STORE) && !off_word && !rst;

  assign wb_data = (ctrl.kind == K_LOAD) ? dmem_rdata : alu_y;
  assign rf_we   = !rst && ((ctrl.kind == K_ARITH) ||
                            (ctrl.kind == K_LOAD && !off_word));
endmodule

// File: rtl/qcore_checker.sv
module qcore_checker (
  input logic        clk,
  input logic        rst,
  input logic [29:0] imem_addr,
  input logic [31:0] imem_data,
  input logic        dmem_we,
  input logic        align_fault
);
  // R1: program counter is zero on the first cycle after reset
  p_pc_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> imem_addr == 30'd0);

  // R2: one word per cycle
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> imem_addr == $past(imem_addr) + 30'd1);

  // R7, R10: stores are the only source of a write strobe
  p_we_store_r7: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> imem_data[31:26] == 6'd43);

  // R9: a flagged access never writes memory
  p_fault_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> !dmem_we);

  // R10: the flag belongs to loads and stores only
  p_fault_memop_r10: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (imem_data[31:26] == 6'd35 || imem_data[31:26] == 6'd43));
endmodule

bind qcore_top qcore_checker u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .align_fault(align_fault)
);

// File: tb/qcore_top_test.sv
module qcore_top_test;
  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] imem_addr;
  logic [31:0] imem_data;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, align_fault;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int n_chk = 0;
  int n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  qcore_top uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .align_fault(align_fault)
  );

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] r_ins(input logic [4:0] rs, rt, rd,
                                        input logic [4:0] sh, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, sh, fn};
  endfunction
  function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] <= 32'd0;
    end
  endtask

  task automatic restart();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to(input int idx);
    for (int k = 0; k < 100 && imem_addr != 30'(idx); k++) @(negedge clk);
  endtask

  task automatic t_reset_step();
    clear_mem();
    imem[0] = i_ins(6'd43, 5'd0, 5'd0, 16'd0);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", {2'b0, imem_addr}, 32'd0);
    check("R1 no write in reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    check("R1 pc after reset", {2'b0, imem_addr}, 32'd0);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      check("R2 pc step", {2'b0, imem_addr}, 32'(i));
    end
  endtask

  task automatic t_arith();
    clear_mem();
    dmem[1] <= 32'd100; dmem[2] <= 32'hFFFF_FFF9;
    dmem[3] <= 32'h7FFF_FFFF; dmem[8] <= 32'd1;
    imem[0]  = i_ins(6'd35, 5'd0, 5'd1, 16'd4);
    imem[1]  = i_ins(6'd35, 5'd0, 5'd2, 16'd8);
    imem[2]  = r_ins(5'd1, 5'd2, 5'd3, 5'd0, 6'd32);
    imem[3]  = r_ins(5'd1, 5'd2, 5'd4, 5'd0, 6'd34);
    imem[4]  = r_ins(5'd2, 5'd1, 5'd5, 5'd0, 6'd34);
    imem[5]  = i_ins(6'd43, 5'd0, 5'd3, 16'd16);
    imem[6]  = i_ins(6'd43, 5'd0, 5'd4, 16'd20);
    imem[7]  = i_ins(6'd43, 5'd0, 5'd5, 16'd24);
    imem[8]  = i_ins(6'd35, 5'd0, 5'd6, 16'd12);
    imem[9]  = i_ins(6'd35, 5'd0, 5'd7, 16'd32);
    imem[10] = r_ins(5'd6, 5'd7, 5'd8, 5'd0, 6'd32);
    imem[11] = r_ins(5'd0, 5'd7, 5'd9, 5'd0, 6'd34);
    imem[12] = i_ins(6'd43, 5'd0, 5'd8, 16'd36);
    imem[13] = i_ins(6'd43, 5'd0, 5'd9, 16'd40);
    restart();
    run_to(5);
    check("R7 store strobe", {31'd0, dmem_we}, 32'd1);
    check("R7 store address", dmem_addr, 32'd16);
    check("R7 store data", dmem_wdata, 32'd93);
    run_to(14);
    check("R3 add", dmem[4], 32'd93);
    check("R4 sub", dmem[5], 32'd107);
    check("R4 sub negative", dmem[6], 32'hFFFF_FF95);
    check("R3 add wraps", dmem[9], 32'h8000_0000);
    check("R4 sub from r0", dmem[10], 32'hFFFF_FFFF);
  endtask

  task automatic t_negoff();
    clear_mem();
    dmem[3] <= 32'h40; dmem[15] <= 32'hCAFE_0001;
    imem[0] = i_ins(6'd35, 5'd0, 5'd6, 16'd12);
    imem[1] = i_ins(6'd35, 5'd6, 5'd7, 16'hFFFC);
    imem[2] = i_ins(6'd43, 5'd6, 5'd7, 16'hFFF8);
    restart();
    run_to(1);
    check("R8 load address below base", dmem_addr, 32'h3C);
    run_to(2);
    check("R8 store address below base", dmem_addr, 32'h38);
    check("R6 loaded value used next cycle", dmem_wdata, 32'hCAFE_0001);
    @(negedge clk);
    check("R8 stored word", dmem[14], 32'hCAFE_0001);
  endtask

  task automatic t_zero_reg();
    clear_mem();
    dmem[1] <= 32'h55; dmem[7] <= 32'hFFFF;
    imem[0] = i_ins(6'd35, 5'd0, 5'd0, 16'd4);
    imem[1] = i_ins(6'd35, 5'd0, 5'd1, 16'd4);
    imem[2] = r_ins(5'd1, 5'd1, 5'd0, 5'd0, 6'd32);
    imem[3] = i_ins(6'd43, 5'd0, 5'd0, 16'd28);
    restart();
    run_to(3);
    check("R5 r0 reads zero", dmem_wdata, 32'd0);
    @(negedge clk);
    check("R5 r0 stored", dmem[7], 32'd0);
  endtask

  task automatic t_misalign();
    clear_mem();
    dmem[1] <= 32'h11; dmem[2] <= 32'h22; dmem[3] <= 32'd8;
    imem[0] = i_ins(6'd35, 5'd0, 5'd2, 16'd12);
    imem[1] = i_ins(6'd35, 5'd0, 5'd3, 16'd4);
    imem[2] = i_ins(6'd43, 5'd2, 5'd3, 16'd2);
    imem[3] = i_ins(6'd35, 5'd2, 5'd3, 16'd1);
    imem[4] = i_ins(6'd43, 5'd2, 5'd3, 16'd0);
    restart();
    run_to(1);
    check("R9 aligned no flag", {31'd0, align_fault}, 32'd0);
    run_to(2);
    check("R9 store flag", {31'd0, align_fault}, 32'd1);
    check("R9 store no strobe", {31'd0, dmem_we}, 32'd0);
    run_to(3);
    check("R9 load flag", {31'd0, align_fault}, 32'd1);
    check("R9 memory untouched", dmem[2], 32'h22);
    run_to(4);
    check("R9 load left register", dmem_wdata, 32'h11);
  endtask

  task automatic t_undecoded();
    clear_mem();
    dmem[1] <= 32'h33; dmem[2] <= 32'h44;
    imem[0] = i_ins(6'd35, 5'd0, 5'd5, 16'd4);
    imem[1] = i_ins(6'd35, 5'd0, 5'd6, 16'd8);
    imem[2] = r_ins(5'd6, 5'd6, 5'd5, 5'd0, 6'd33);
    imem[3] = i_ins(6'd8, 5'd6, 5'd5, 16'd1);
    imem[4] = r_ins(5'd6, 5'd6, 5'd5, 5'd1, 6'd32);
    imem[5] = i_ins(6'd41, 5'd0, 5'd6, 16'd4);
    imem[6] = i_ins(6'd43, 5'd0, 5'd5, 16'd0);
    restart();
    for (int i = 2; i <= 5; i++) begin
      run_to(i);
      check("R10 no strobe", {31'd0, dmem_we}, 32'd0);
      check("R10 no flag", {31'd0, align_fault}, 32'd0);
    end
    run_to(6);
    check("R10 register kept", dmem_wdata, 32'h33);
    @(negedge clk);
    check("R10 memory kept", dmem[1], 32'h33);
  endtask

  initial begin
    t_reset_step();
    t_arith();
    t_negoff();
    t_zero_reg();
    t_misalign();
    t_undecoded();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule